// File: doc/BRIEF.md
# Hierarchical Frame Configuration Memory for a Logic Element

This block holds the configuration bits of one logic element of a programmable fabric. Its write path is a two-level tree of address decoders. The top frame decoder looks at the most significant address bit and enables one of two sub-frames. One sub-frame stores the lookup-table bits and the other stores the routing-multiplexer select bits. The enabled sub-frame decodes the low address bits and raises the word-line of exactly one cell. That cell then captures the single shared data bit from its bit-line on the rising clock edge.

A configuration controller loads the element one bit at a time. It raises the frame enable, puts a cell address and a data bit on the inputs, and holds them for one clock. Every cell drives its stored value and the complement of that value to the fabric continuously. The number of cells in each sub-frame is a parameter. The address width is derived as one selection bit plus enough index bits for the larger sub-frame.

Top module: `cfgf_le_frame`

## Requirements
- R1: A synchronous active-low reset clears every cell to 0. After the first rising edge with `rst_n` low, `lut_q` and `mux_q` are all 0 and `lut_qn` and `mux_qn` are all 1.
- R2: Address bit [2] (the most significant address bit) chooses the sub-frame. A value of 0 selects the lookup-table sub-frame and a value of 1 selects the routing-multiplexer sub-frame. A write never changes any bit of the sub-frame that was not selected.
- R3: Address bits [1:0] give the index of the cell inside the selected sub-frame. Index n writes bit n of `lut_q` or bit n of `mux_q`.
- R4: When `frame_en` is 1 at a rising edge, the addressed cell takes the value of `din` present at that edge.
- R5: A write changes only the addressed cell. Every other cell in both sub-frames keeps its value.
- R6: When `frame_en` is 0 at a rising edge, no cell changes, whatever `addr` and `din` are.
- R7: Every inverted output bit is the complement of its true output bit at all times.
- R8: At most one word-line in the whole element is high in any cycle.
- R9: A written value appears on the outputs after the rising edge that performs the write and stays there until that cell is written again or reset. Writing a cell again replaces its earlier value, including a change from 1 back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; cells update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset, clears all cells |
| frame_en | input | 1 | Enables the top frame decoder for a write |
| addr | input | ADDR_W (3) | Bit [2] selects the sub-frame, bits [1:0] select the cell |
| din | input | 1 | Shared data bit driven onto every bit-line |
| lut_q | output | LUT_CELLS (4) | Stored lookup-table configuration bits |
| lut_qn | output | LUT_CELLS (4) | Complement of `lut_q` |
| mux_q | output | MUX_CELLS (4) | Stored routing-multiplexer select bits |
| mux_qn | output | MUX_CELLS (4) | Complement of `mux_q` |

## Verification
A write or a reset is applied on one rising edge, and all four output buses show the result immediately after that edge. No result arrives later than one edge after its stimulus. The bench changes the inputs on the falling edge, lets exactly one rising edge pass, and samples every output bus on the following falling edge. It compares the sampled values with a reference image of the element that a bench function updates for the same operation. Disabled writes, resets in the middle of a run and overwrites are sampled the same way, so every stimulus is checked exactly one edge after it takes effect.

// File: rtl/cfgf_pkg.sv
// Package cfgf_pkg
// Shared types and width helpers for the frame configuration memory.
// Assumes that sub-frame sizes are at least one cell.
package cfgf_pkg;

    // Sub-frame identifiers. The value equals the top address bit that selects the sub-frame.
    typedef enum logic [0:0] {
        SF_LUT = 1'b0,
        SF_MUX = 1'b1
    } subframe_e;

    localparam int NUM_SUBFRAMES = 2;

    // Returns the number of index bits needed to address n cells (at least 1).
    function automatic int idx_bits(input int n);
        int w;
        w = 1;
        while ((1 << w) < n) begin
            w++;
        end
        return w;
    endfunction

    // Returns the index width needed for the larger of two sub-frames.
    function automatic int max_idx_bits(input int a, input int b);
        return (a > b) ? idx_bits(a) : idx_bits(b);
    endfunction

endpackage

// File: rtl/cfgf_decoder.sv
// Module cfgf_decoder
// Enabled one-hot address decoder used at every frame level.
// When en is high, the output bit whose position equals sel is raised.
// A sel at or above N raises nothing.
// Assumes N <= 2**SEL_W.
module cfgf_decoder #(
    parameter int N     = 4,
    parameter int SEL_W = 2
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [N-1:0]     line
);

    // One comparator per output line.
    for (genvar g = 0; g < N; g++) begin : g_line
        assign line[g] = en && (sel == SEL_W'(g));
    end

    // Decoder outputs never have two lines high together.
    always_comb begin
        AST_DEC_ONEHOT: assert ($onehot0(line)); // R8
    end

endmodule

// File: rtl/cfgf_cell.sv
// Module cfgf_cell
// One configuration memory cell: a flop that loads its bit-line while its word-line is high.
// Drives the stored bit and its complement. Uses a synchronous active-low reset that wins over a write.
module cfgf_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic wl,
    input  logic bl,
    output logic q,
    output logic qn
);

    logic store_q;

    // Storage update: reset, write, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= 1'b0;
        end else if (wl) begin
            store_q <= bl;
        end
    end

    // Complementary output pair.
    assign q  = store_q;
    assign qn = ~store_q;

    AST_CELL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wl |=> (q == $past(bl))); // R4

    AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wl |=> $stable(q)); // R5

endmodule

// File: rtl/cfgf_subframe.sv
// Module cfgf_subframe
// One sub-frame: a local decoder plus CELLS memory cells sharing one bit-line.
// Assumes en comes from the parent decoder, and that idx values at or above CELLS are
// harmless because they decode to no cell.
module cfgf_subframe #(
    parameter int CELLS = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    input  logic             bl,
    output logic [CELLS-1:0] wl,
    output logic [CELLS-1:0] q,
    output logic [CELLS-1:0] qn
);

    // Local word-line decoder enabled by the parent frame.
    cfgf_decoder #(
        .N     (CELLS),
        .SEL_W (IDX_W)
    ) u_dec (
        .en   (en),
        .sel  (idx),
        .line (wl)
    );

    // Cell array of this sub-frame.
    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        cfgf_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .wl    (wl[c]),
            .bl    (bl),
            .q     (q[c]),
            .qn    (qn[c])
        );
    end

    AST_SF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q)); // R2

endmodule

// File: rtl/cfgf_le_frame.sv
// Module cfgf_le_frame
// Configuration memory of one logic element, written through a two-level frame decoder.
// The top address bit picks the lookup-table or the routing-multiplexer sub-frame, and the
// low bits pick a cell in it. Assumes addr and din are stable around the rising edge.
module cfgf_le_frame #(
    parameter int LUT_CELLS = 4,
    parameter int MUX_CELLS = 4,
    parameter int IDX_W     = cfgf_pkg::max_idx_bits(LUT_CELLS, MUX_CELLS),
    parameter int ADDR_W    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic [LUT_CELLS-1:0] lut_q,
    output logic [LUT_CELLS-1:0] lut_qn,
    output logic [MUX_CELLS-1:0] mux_q,
    output logic [MUX_CELLS-1:0] mux_qn
);

    import cfgf_pkg::*;

    localparam int SEL_MSB = ADDR_W - 1;

    logic [NUM_SUBFRAMES-1:0] sf_en;
    logic [IDX_W-1:0]         cell_idx;
    logic [LUT_CELLS-1:0]     lut_wl;
    logic [MUX_CELLS-1:0]     mux_wl;

    // Split the address into the sub-frame select and the cell index.
    assign cell_idx = addr[IDX_W-1:0];

    // Top frame decoder: enables one sub-frame decoder.
    cfgf_decoder #(
        .N     (NUM_SUBFRAMES),
        .SEL_W (1)
    ) u_top_dec (
        .en   (frame_en),
        .sel  (addr[SEL_MSB]),
        .line (sf_en)
    );

    // Lookup-table sub-frame.
    cfgf_subframe #(
        .CELLS (LUT_CELLS),
        .IDX_W (IDX_W)
    ) u_lut_sf (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sf_en[SF_LUT]),
        .idx   (cell_idx),
        .bl    (din),
        .wl    (lut_wl),
        .q     (lut_q),
        .qn    (lut_qn)
    );

    // Routing-multiplexer sub-frame.
    cfgf_subframe #(
        .CELLS (MUX_CELLS),
        .IDX_W (IDX_W)
    ) u_mux_sf (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sf_en[SF_MUX]),
        .idx   (cell_idx),
        .bl    (din),
        .wl    (mux_wl),
        .q     (mux_q),
        .qn    (mux_qn)
    );

    AST_ONE_WORDLINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lut_wl, mux_wl})); // R8

    AST_FRAME_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_en |=> ($stable(lut_q) && $stable(mux_q))); // R6

    AST_LUT_SEL_SPARES_MUX: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_en && !addr[SEL_MSB]) |=> $stable(mux_q)); // R2

    AST_MUX_SEL_SPARES_LUT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_en && addr[SEL_MSB]) |=> $stable(lut_q)); // R2

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((lut_q ^ lut_qn) == '1) && ((mux_q ^ mux_qn) == '1)); // R7

endmodule

// File: tb/cfgf_le_frame_tb.sv
// Bench for cfgf_le_frame: directed corner cases plus seeded random writes,
// checked against a bench reference image of all cells.
module cfgf_le_frame_tb;

    localparam int LUT_CELLS = 4;
    localparam int MUX_CELLS = 4;
    localparam int ADDR_W    = 3;

    logic              clk;
    logic              rst_n;
    logic              frame_en;
    logic [ADDR_W-1:0] addr;
    logic              din;
    logic [LUT_CELLS-1:0] lut_q, lut_qn;
    logic [MUX_CELLS-1:0] mux_q, mux_qn;

    logic [LUT_CELLS-1:0] exp_lut;
    logic [MUX_CELLS-1:0] exp_mux;

    int n_cmp;
    int n_bad;

    cfgf_le_frame #(
        .LUT_CELLS (LUT_CELLS),
        .MUX_CELLS (MUX_CELLS)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_en (frame_en),
        .addr     (addr),
        .din      (din),
        .lut_q    (lut_q),
        .lut_qn   (lut_qn),
        .mux_q    (mux_q),
        .mux_qn   (mux_qn)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Reference image after a write: bit [2] picks the sub-frame, bits [1:0] pick the cell.
    function automatic logic [7:0] ref_write(input logic [7:0] img, input logic en,
                                             input logic [2:0] a, input logic d);
        logic [7:0] r;
        r = img;
        if (en) begin
            r[{a[2], a[1:0]}] = d;
        end
        return r;
    endfunction

    task automatic cmp(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Compare all four output buses with the reference image.
    task automatic check_all(input string tag);
        cmp(tag, "lut_q", lut_q, exp_lut);
        cmp(tag, "mux_q", mux_q, exp_mux);
        cmp("R7", "lut_qn", lut_qn, ~exp_lut);
        cmp("R7", "mux_qn", mux_qn, ~exp_mux);
    endtask

    // Drive one operation at the falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic op(input logic en, input logic [2:0] a, input logic d, input string tag);
        logic [7:0] img;
        frame_en = en;
        addr     = a;
        din      = d;
        @(posedge clk);
        img = ref_write({exp_mux, exp_lut}, en, a, d);
        exp_lut = img[3:0];
        exp_mux = img[7:4];
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        frame_en = 1'b1;
        addr     = 3'd5;
        din      = 1'b1;
        @(posedge clk);
        exp_lut = '0;
        exp_mux = '0;
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        n_cmp = 0;
        n_bad = 0;
        exp_lut = '0;
        exp_mux = '0;
        rst_n = 1'b0;
        frame_en = 1'b0;
        addr = '0;
        din = 1'b0;
        seed_dummy = $urandom(32'h5EED_0C0F);
        @(negedge clk);
        do_reset();

        // R3: each lookup-table cell by index, then each multiplexer cell (R2).
        for (int i = 0; i < 4; i++) op(1'b1, {1'b0, 2'(i)}, 1'b1, "R3");
        for (int i = 0; i < 4; i++) op(1'b1, {1'b1, 2'(i)}, 1'b1, "R2");
        // R9: overwrite with 0 in alternate cells; R5: neighbours must keep 1.
        op(1'b1, 3'd1, 1'b0, "R9");
        op(1'b1, 3'd6, 1'b0, "R5");
        op(1'b1, 3'd1, 1'b0, "R4");
        // R6: frame enable low with every address and both data values.
        for (int i = 0; i < 8; i++) op(1'b0, 3'(i), ~exp_lut[i % 4], "R6");
        // R9: values hold across idle cycles.
        op(1'b0, 3'd0, 1'b0, "R9");
        // R1: reset in the middle of a run clears everything.
        do_reset();
        // R4: single write after reset.
        op(1'b1, 3'd7, 1'b1, "R4");

        // R5: seeded random mix of enabled and disabled writes.
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            op(r[0] | r[1], r[4:2], r[5], "R5");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule